// File: doc/BRIEF.md
# Bit Code Store Controller

This block is a clocked command processor that fills a short serial code, one bit at a time, into a fixed-length internal store. Every clock it acts on exactly one 3-bit command with a companion data bit. It reports what it did through three registered outputs: a 2-bit acknowledge, a 2-bit output data code and a 1-bit drive enable.

The controller has three modes. In fill mode it accepts loads, a restart, a query and the command that starts a dump. In dump mode it plays the stored code back at one bit per cycle, starting at position 0. In armed mode it holds the drive enable high. A query moves it into armed mode only once the store is completely filled. A restart is the only command that takes it out of armed mode. A restart also clears the fill position. It does not erase the stored bits.

Top module: `code_store_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released, the outputs are ack=0 (NONE), dout=0 (EMPTY) and drive=0. The controller starts in fill mode with fill position 0.
- R2: A LOAD command (cmd=1) in fill mode gives ack=1 (LOADED), dout=0 and drive=0 on the next cycle.
- R3: In fill mode, a LOAD while the fill position is below CODE_LEN writes data_i at that position and advances the position by one. A LOAD while the position equals CODE_LEN stores nothing and leaves the position at CODE_LEN.
- R4: A RESTART command (cmd=2) in any mode returns the controller to fill mode with fill position 0, gives ack=0, dout=0 and drive=0, and leaves the stored bits unchanged.
- R5: The NOP command (cmd=0) and the unused codes 5 to 7 change neither the fill position nor the mode, and give ack=0, dout=0 and drive=0 in fill mode.
- R6: A DUMP command (cmd=4) in fill mode gives ack=3 (READ) with dout=0 on the next cycle. On each of the following CODE_LEN cycles, ack=3 and dout shows stored bit k for k=0,1,... in turn, with dout=2 for a 0 and dout=3 for a 1. The controller then returns to fill mode. Commands other than RESTART are ignored during the dump.
- R7: A QUERY command (cmd=3) in fill mode with the position equal to CODE_LEN gives ack=2 (FULL) and drive=1 on the next cycle and enters armed mode. With the position below CODE_LEN, a QUERY gives ack=0 and the controller stays in fill mode.
- R8: In armed mode, drive=1, ack=0 and dout=0 on every cycle. Every command other than RESTART is ignored, including LOAD, which does not alter the store.
- R9: All outputs produced by one command change together, on the clock edge that samples the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_i | input | 3 | Command code: 0 NOP, 1 LOAD, 2 RESTART, 3 QUERY, 4 DUMP |
| data_i | input | 1 | Bit written by LOAD |
| ack_o | output | 2 | Acknowledge: 0 NONE, 1 LOADED, 2 FULL, 3 READ |
| dout_o | output | 2 | Output data: 0 EMPTY, 2 bit zero, 3 bit one |
| drive_o | output | 1 | Drive enable, 1 in armed mode |

## Verification
The hardest situations to reach from the ports are those where a command arrives while the controller is not in fill mode. Examples are a LOAD during a dump or in armed mode, and a RESTART midway through playback. In these cases the store must stay untouched and the fill position must not move. The stimulus fills the store completely and overfills it. It then issues loads inside a dump and inside armed mode. It proves that they had no effect by dumping the store again afterwards. It also restarts after a partial refill, so the dump shows new bits followed by surviving old ones.

// File: rtl/code_store_pkg.sv
package code_store_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_LOAD    = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_QUERY   = 3'd3,
    CMD_DUMP    = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ACK_NONE   = 2'd0,
    ACK_LOADED = 2'd1,
    ACK_FULL   = 2'd2,
    ACK_READ   = 2'd3
  } ack_e;

  localparam logic [1:0] DOUT_EMPTY = 2'b00;
  localparam logic [1:0] DOUT_ZERO  = 2'b10;
  localparam logic [1:0] DOUT_ONE   = 2'b11;

  typedef enum logic [1:0] {
    MODE_FILL  = 2'd0,
    MODE_DUMP  = 2'd1,
    MODE_ARMED = 2'd2
  } mode_e;

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cs_fill_ctr.sv
module cs_fill_ctr #(
  parameter int CODE_LEN = 8,
  parameter int CW       = $clog2(CODE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  localparam logic [CW-1:0] TOP = CW'(CODE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign full_o = (cnt_q == TOP);
  assign cnt_en = clr_i | (inc_i & ~full_o);

  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && full_o) |=> (cnt_q == TOP));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && !full_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/cs_bit_store.sv
module cs_bit_store #(
  parameter int CODE_LEN = 8,
  parameter int CW       = $clog2(CODE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_idx_i,
  input  logic          wr_bit_i,
  input  logic [CW-1:0] rd_idx_i,
  output logic          rd_bit_o
);
  logic [CODE_LEN-1:0] mem_q;

  for (genvar i = 0; i < CODE_LEN; i++) begin : g_cell
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= 1'b0;
      else if (hit) mem_q[i] <= wr_bit_i;
    end
  end

  always_comb begin
    rd_bit_o = 1'b0;
    for (int i = 0; i < CODE_LEN; i++) begin
      if (rd_idx_i == CW'(i)) rd_bit_o = mem_q[i];
    end
  end

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_bit_i)));

  a_r8_hold_store: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import code_store_pkg::*;
#(
  parameter int CODE_LEN = 8,
  parameter int CW       = $clog2(CODE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_i,
  input  logic          full_i,
  input  logic          rd_bit_i,
  output logic          load_en_o,
  output logic          clr_o,
  output logic [CW-1:0] rd_ptr_o,
  output logic [1:0]    ack_o,
  output logic [1:0]    dout_o,
  output logic          drive_o
);
  localparam logic [CW-1:0] LAST = CW'(CODE_LEN - 1);

  mode_e         mode_q, mode_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic [1:0]    ack_q, ack_d, dout_q, dout_d;
  logic          drv_q, drv_d;

  always_comb begin
    mode_d    = mode_q;
    ptr_d     = ptr_q;
    ptr_en    = 1'b0;
    ack_d     = ACK_NONE;
    dout_d    = DOUT_EMPTY;
    drv_d     = 1'b0;
    load_en_o = 1'b0;
    clr_o     = (cmd_i == CMD_RESTART);
    if (clr_o) begin
      mode_d = MODE_FILL;
    end else begin
      case (mode_q)
        MODE_FILL: begin
          case (cmd_i)
            CMD_LOAD: begin
              ack_d     = ACK_LOADED;
              load_en_o = 1'b1;
            end
            CMD_DUMP: begin
              mode_d = MODE_DUMP;
              ptr_d  = '0;
              ptr_en = 1'b1;
              ack_d  = ACK_READ;
            end
            CMD_QUERY: begin
              if (full_i) begin
                ack_d  = ACK_FULL;
                mode_d = MODE_ARMED;
                drv_d  = 1'b1;
              end
            end
            default: ;
          endcase
        end
        MODE_DUMP: begin
          ack_d  = ACK_READ;
          dout_d = rd_bit_i ? DOUT_ONE : DOUT_ZERO;
          ptr_d  = ptr_q + CW'(1);
          ptr_en = 1'b1;
          if (ptr_q == LAST) mode_d = MODE_FILL;
        end
        MODE_ARMED: drv_d = 1'b1;
        default:    mode_d = MODE_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FILL;
      ack_q  <= ACK_NONE;
      dout_q <= DOUT_EMPTY;
      drv_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ack_q  <= ack_d;
      dout_q <= dout_d;
      drv_q  <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign rd_ptr_o = ptr_q;
  assign ack_o    = ack_q;
  assign dout_o   = dout_q;
  assign drive_o  = drv_q;

  a_r2_load_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FILL && cmd_i == CMD_LOAD) |=>
      (ack_o == ACK_LOADED && dout_o == DOUT_EMPTY && !drive_o));

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_RESTART) |=>
      (mode_q == MODE_FILL && ack_o == ACK_NONE && !drive_o));

  a_r6_dump_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DUMP && cmd_i != CMD_RESTART) |=>
      (ack_o == ACK_READ && dout_o[1]));

  a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FILL && cmd_i == CMD_QUERY && full_i) |=>
      (ack_o == ACK_FULL && drive_o && mode_q == MODE_ARMED));

  a_r8_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARMED && cmd_i != CMD_RESTART) |=>
      (mode_q == MODE_ARMED && drive_o && ack_o == ACK_NONE));

  a_r8_no_load_outside_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_FILL) |-> !load_en_o);
endmodule

// File: rtl/code_store_ctrl.sv
module code_store_ctrl #(
  parameter int CODE_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_i,
  input  logic       data_i,
  output logic [1:0] ack_o,
  output logic [1:0] dout_o,
  output logic       drive_o
);
  localparam int CW = $clog2(CODE_LEN + 1);

  logic          rst_n_int;
  logic          load_en, clr, full, rd_bit;
  logic [CW-1:0] cnt, rd_ptr;

  cs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cs_fill_ctr #(.CODE_LEN(CODE_LEN), .CW(CW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .inc_i  (load_en),
    .clr_i  (clr),
    .cnt_o  (cnt),
    .full_o (full)
  );

  cs_bit_store #(.CODE_LEN(CODE_LEN), .CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en_i  (load_en & ~full),
    .wr_idx_i (cnt),
    .wr_bit_i (data_i),
    .rd_idx_i (rd_ptr),
    .rd_bit_o (rd_bit)
  );

  cs_sequencer #(.CODE_LEN(CODE_LEN), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_i     (cmd_i),
    .full_i    (full),
    .rd_bit_i  (rd_bit),
    .load_en_o (load_en),
    .clr_o     (clr),
    .rd_ptr_o  (rd_ptr),
    .ack_o     (ack_o),
    .dout_o    (dout_o),
    .drive_o   (drive_o)
  );
endmodule

// File: tb/code_store_ctrl_test.sv
module code_store_ctrl_test;
  localparam int LEN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic       data = 1'b0;
  logic [1:0] ack, dout;
  logic       drive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_mode = 0;       // 0 fill, 1 dump, 2 armed
  int m_cnt = 0;
  int m_rp = 0;
  bit m_mem[LEN];
  int e_ack = 0, e_dout = 0, e_drv = 0;

  always #4 clk = ~clk;

  code_store_ctrl #(.CODE_LEN(LEN)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .data_i(data),
    .ack_o(ack), .dout_o(dout), .drive_o(drive)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string tag);
    checks++;
    if (ack !== e_ack[1:0] || dout !== e_dout[1:0] || drive !== e_drv[0]) begin
      failures++;
      $display("FAIL %s: ack=%0d dout=%0d drive=%0d expected ack=%0d dout=%0d drive=%0d",
               tag, ack, dout, drive, e_ack, e_dout, e_drv);
    end
  endtask

  task automatic model(int c, bit d);
    e_ack = 0; e_dout = 0; e_drv = 0;
    if (c == 2) begin
      m_mode = 0; m_cnt = 0;
    end else if (m_mode == 0) begin
      if (c == 1) begin
        e_ack = 1;
        if (m_cnt < LEN) begin m_mem[m_cnt] = d; m_cnt++; end
      end else if (c == 4) begin
        m_mode = 1; m_rp = 0; e_ack = 3;
      end else if (c == 3 && m_cnt == LEN) begin
        e_ack = 2; e_drv = 1; m_mode = 2;
      end
    end else if (m_mode == 1) begin
      e_ack = 3;
      e_dout = m_mem[m_rp] ? 3 : 2;
      if (m_rp == LEN - 1) m_mode = 0;
      m_rp++;
    end else begin
      e_drv = 1;
    end
  endtask

  task automatic step(int c, bit d, string tag);
    cmd = 3'(c); data = d;
    @(posedge clk);
    model(c, d);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    bit pat[LEN] = '{1, 0, 1, 1, 0, 0, 1, 0};
    for (int i = 0; i < LEN; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release");

    step(0, 0, "R5 nop");
    step(6, 1, "R5 unused code 6");
    step(7, 0, "R5 unused code 7");
    step(3, 0, "R7 query while empty");
    for (int i = 0; i < LEN; i++) step(1, pat[i], "R2 R3 load");
    step(1, 1, "R3 load past capacity");
    step(1, 1, "R3 load past capacity again");
    step(4, 0, "R6 dump start");
    for (int i = 0; i < LEN; i++) step((i % 2 == 0) ? 1 : 3, 1, "R6 dump bit, load ignored");
    step(0, 0, "R6 back in fill");
    step(2, 0, "R4 restart");
    for (int i = 0; i < 3; i++) step(1, 0, "R4 refill from position 0");
    step(3, 0, "R7 query when partly full");
    step(4, 0, "R4 R6 dump shows new then old bits");
    for (int i = 0; i < LEN; i++) step(0, 0, "R4 R6 dump bit");
    for (int i = 0; i < LEN - 3; i++) step(1, 1, "R3 top up");
    step(3, 0, "R7 query when full arms");
    step(1, 0, "R8 load ignored while armed");
    step(4, 0, "R8 dump ignored while armed");
    step(3, 0, "R8 query ignored while armed");
    step(0, 0, "R8 nop while armed");
    step(2, 0, "R4 restart from armed");
    step(4, 0, "R8 dump after armed loads");
    for (int i = 0; i < LEN; i++) step(0, 0, "R8 store unchanged");
    step(4, 0, "R6 dump again");
    step(0, 0, "R6 first bit");
    step(0, 0, "R6 second bit");
    step(2, 0, "R4 restart mid dump");
    step(0, 0, "R5 nop after restart");
    step(3, 0, "R9 query not full after restart");
    step(1, 1, "R9 load after restart");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule